// File: doc/BRIEF.md
# Single-Wire Identity Search Master

This block discovers, one by one, the identities of all slave devices that share an open-drain single-wire bus. It does not generate the bus waveforms itself. It sits above a bit-level engine and hands that engine one operation at a time: a bus reset, a write of 0, a write of 1, or a read. The engine answers each operation with an acknowledge pulse and a sampled bit.

Each pass starts with a reset. The pass then sends the search command byte. After that it walks every identity bit position. At each position the block takes two reads: the wired-AND of every still-active slave's bit, then the wired-AND of the complemented bits. It then writes back the direction it chose, and slaves whose bit differs drop out for the rest of the pass. The positions where the tree forks are remembered from one pass to the next, so each new pass takes the next unexplored branch. One identity comes out per pass until no fork is left.

The host pulses `start` and then waits until `busy` falls. Each identity appears on `id_out` together with a one-cycle `id_valid`. The search ends with exactly one of three terminal flags: `done`, `no_dev` or `err`.

Top module: `owsrch_master`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `bus_req`, `id_valid`, `done`, `no_dev` and `err` are all low.
- R2: Every pass starts with a request of `bus_op` = 0 (reset). If the returned `bus_rbit` is 0 (no presence), the search stops with `no_dev` high and emits no identity.
- R3: After presence, the block issues eight writes carrying the byte F0h, least significant bit first: `bus_op` 1 means write 0 and 2 means write 1, so the order is 0,0,0,0,1,1,1,1.
- R4: For each identity bit position, from bit 0 upward, the block issues a read (`bus_op` = 3), a second read, and then one write. When the two reads differ, the value written equals the first read.
- R5: When both reads are 0 (a fork), the write repeats the previous pass's bit if the position lies below the previous pass's last zero-branch fork, writes 1 at that fork, and writes 0 above it. Taken together, passes return identities in ascending order when bit 0 is treated as most significant.
- R6: When both reads of a position are 1, the pass is abandoned: `err` rises, `busy` falls, and no identity is emitted for that pass.
- R7: At the end of each full pass, `id_valid` is high for exactly one cycle, and `id_out` bit i holds the value written at position i.
- R8: Each slave identity on the bus is emitted exactly once per search, and no other value is emitted.
- R9: The search ends with `done` after the first pass that takes no zero branch at any fork. `done`, `no_dev` and `err` are never high together, and each holds until the next accepted `start`, which clears it.
- R10: `bus_op` stays constant while `bus_req` is high and `bus_ack` has not yet arrived. A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new search when idle |
| bus_req | output | 1 | Operation request to the bit engine, held until acknowledged |
| bus_op | output | 2 | 0 reset, 1 write 0, 2 write 1, 3 read |
| bus_ack | input | 1 | One-cycle completion pulse from the bit engine |
| bus_rbit | input | 1 | Presence (reset) or sampled bit (read), valid with `bus_ack` |
| id_out | output | ID_W | Identity found by the latest pass |
| id_valid | output | 1 | One-cycle strobe marking a new identity |
| busy | output | 1 | Search in progress |
| done | output | 1 | All identities found |
| no_dev | output | 1 | No presence seen at pass start |
| err | output | 1 | Pass abandoned after a 1/1 read pair |

## Verification
The embedded properties check, on every cycle, the things a single cycle can settle. These are: the request/opcode holding rule, the single-cycle width of `id_valid`, the exclusivity of the terminal flags, a reset being the first operation of a search, `busy` dropping together with an error, and the per-pass fork position only moving upward. Whether the fork memory really walks the whole tree shows only across whole searches. So the bench models a population of slaves as a wired-AND and sweeps many populations of a six-bit configuration, up to every one of the 64 identities. It predicts the exact write sequence and the emission order arithmetically, by sorting on the bit-reversed value. The empty bus, slaves that vanish after presence, and a stray `start` in the middle of a search are scenario-only cases.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WR0   = 2'd1,
    OP_WR1   = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RST  = 3'd1,
    S_CMD  = 3'd2,
    S_RD0  = 3'd3,
    S_RD1  = 3'd4,
    S_WR   = 3'd5,
    S_EMIT = 3'd6
  } state_e;

  // search command byte, sent least significant bit first
  localparam logic [7:0] SEARCH_CMD = 8'hF0;

endpackage

// File: rtl/owsrch_idreg.sv
module owsrch_idreg #(
  parameter int ID_W  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             load_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             dir,
  output logic             cur_bit,
  output logic [ID_W-1:0]  id_q
);

  logic [ID_W-1:0] id_d;

  for (genvar gi = 0; gi < ID_W; gi++) begin : g_bit
    always_comb begin
      id_d[gi] = id_q[gi];
      if (load_en && (int'(idx) == gi)) id_d[gi] = dir;
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) id_q[gi] <= 1'b0;
      else         id_q[gi] <= id_d[gi];
    end
  end

  always_comb begin
    cur_bit = 1'b0;
    if (int'(idx) < ID_W) cur_bit = id_q[idx];
  end

  // R7
  load_in_range_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    load_en |-> (int'(idx) < ID_W));

endmodule

// File: rtl/owsrch_disc.sv
module owsrch_disc #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             clr_search,
  input  logic             clr_pass,
  input  logic             decide,
  input  logic             end_pass,
  input  logic             rd_true,
  input  logic             rd_cmpl,
  input  logic [POS_W-1:0] pos,
  input  logic             prev_bit,
  output logic             dir,
  output logic             more
);

  logic [POS_W-1:0] last_disc_q, last_disc_d;
  logic [POS_W-1:0] last_zero_q, last_zero_d;
  logic             fork_seen;

  always_comb begin
    fork_seen = (rd_true == rd_cmpl);
    if (!fork_seen)             dir = rd_true;
    else if (pos < last_disc_q) dir = prev_bit;
    else if (pos == last_disc_q) dir = 1'b1;
    else                        dir = 1'b0;
  end

  always_comb begin
    last_disc_d = last_disc_q;
    last_zero_d = last_zero_q;
    if (clr_search) begin
      last_disc_d = '0;
      last_zero_d = '0;
    end else if (clr_pass) begin
      last_zero_d = '0;
    end else if (decide && fork_seen && !dir) begin
      last_zero_d = pos;
    end else if (end_pass) begin
      last_disc_d = last_zero_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      last_disc_q <= '0;
      last_zero_q <= '0;
    end else begin
      last_disc_q <= last_disc_d;
      last_zero_q <= last_zero_d;
    end
  end

  assign more = (last_zero_q != '0);

  // R5
  zero_fork_rising_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    decide |=> (last_zero_q >= $past(last_zero_q)));

endmodule

// File: rtl/owsrch_ctrl.sv
module owsrch_ctrl
  import owsrch_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int IDX_W = 6,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             start,
  input  logic             bus_ack,
  input  logic             bus_rbit,
  input  logic             cur_bit,
  input  logic             more,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic [IDX_W-1:0] idx,
  output logic [POS_W-1:0] pos,
  output logic             rd_true,
  output logic             decide,
  output logic             clr_search,
  output logic             clr_pass,
  output logic             end_pass,
  output logic             id_valid,
  output logic             busy,
  output logic             done,
  output logic             no_dev,
  output logic             err
);

  localparam int CNT_W = (IDX_W > 3) ? IDX_W : 3;
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(7);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd0_q, rd0_d;
  logic             done_q, done_d, nodev_q, nodev_d, err_q, err_d;

  assign idx = cnt_q[IDX_W-1:0];
  assign pos = POS_W'(idx) + POS_W'(1);

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd0_d   = rd0_q;
    done_d  = done_q;
    nodev_d = nodev_q;
    err_d   = err_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d = S_RST;
        done_d  = 1'b0;
        nodev_d = 1'b0;
        err_d   = 1'b0;
      end
      S_RST: if (bus_ack) begin
        if (bus_rbit) begin
          state_d = S_CMD;
          cnt_d   = '0;
        end else begin
          state_d = S_IDLE;
          nodev_d = 1'b1;
        end
      end
      S_CMD: if (bus_ack) begin
        if (cnt_q == CMD_LAST) begin
          cnt_d   = '0;
          state_d = S_RD0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      S_RD0: if (bus_ack) begin
        rd0_d   = bus_rbit;
        state_d = S_RD1;
      end
      S_RD1: if (bus_ack) begin
        if (rd0_q && bus_rbit) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_WR;
        end
      end
      S_WR: if (bus_ack) begin
        if (idx == IDX_LAST) state_d = S_EMIT;
        else begin
          cnt_d   = cnt_q + CNT_W'(1);
          state_d = S_RD0;
        end
      end
      S_EMIT: begin
        if (more) state_d = S_RST;
        else begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rd0_q   <= 1'b0;
      done_q  <= 1'b0;
      nodev_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd0_q   <= rd0_d;
      done_q  <= done_d;
      nodev_q <= nodev_d;
      err_q   <= err_d;
    end
  end

  // output decode
  always_comb begin
    bus_op = OP_READ;
    unique case (state_q)
      S_RST:   bus_op = OP_RESET;
      S_CMD:   bus_op = SEARCH_CMD[cnt_q[2:0]] ? OP_WR1 : OP_WR0;
      S_WR:    bus_op = cur_bit ? OP_WR1 : OP_WR0;
      default: bus_op = OP_READ;
    endcase
  end

  assign bus_req    = (state_q == S_RST) || (state_q == S_CMD) || (state_q == S_RD0) ||
                      (state_q == S_RD1) || (state_q == S_WR);
  assign rd_true    = rd0_q;
  assign decide     = (state_q == S_RD1) && bus_ack && !(rd0_q && bus_rbit);
  assign clr_search = (state_q == S_IDLE) && start;
  assign clr_pass   = (state_q == S_RST) && bus_ack && bus_rbit;
  assign end_pass   = (state_q == S_EMIT);
  assign id_valid   = (state_q == S_EMIT);
  assign busy       = (state_q != S_IDLE);
  assign done       = done_q;
  assign no_dev     = nodev_q;
  assign err        = err_q;

  // R10
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op)));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    id_valid |=> !id_valid);

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({done, no_dev, err}));

  // R2
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy) |-> (bus_req && bus_op == OP_RESET));

  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(err) |-> !busy);

endmodule

// File: rtl/owsrch_master.sv
module owsrch_master #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            bus_req,
  output logic [1:0]      bus_op,
  input  logic            bus_ack,
  input  logic            bus_rbit,
  output logic [ID_W-1:0] id_out,
  output logic            id_valid,
  output logic            busy,
  output logic            done,
  output logic            no_dev,
  output logic            err
);

  localparam int IDX_W = (ID_W > 2) ? $clog2(ID_W) : 1;
  localparam int POS_W = $clog2(ID_W + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_ns;
  logic             cur_bit, more, dir;
  logic [IDX_W-1:0] idx;
  logic [POS_W-1:0] pos;
  logic             rd_true, decide, clr_search, clr_pass, end_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  owsrch_ctrl #(.ID_W(ID_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_ns(rst_ns), .start(start), .bus_ack(bus_ack), .bus_rbit(bus_rbit),
    .cur_bit(cur_bit), .more(more), .bus_req(bus_req), .bus_op(bus_op), .idx(idx),
    .pos(pos), .rd_true(rd_true), .decide(decide), .clr_search(clr_search),
    .clr_pass(clr_pass), .end_pass(end_pass), .id_valid(id_valid), .busy(busy),
    .done(done), .no_dev(no_dev), .err(err)
  );

  owsrch_disc #(.POS_W(POS_W)) u_disc (
    .clk(clk), .rst_ns(rst_ns), .clr_search(clr_search), .clr_pass(clr_pass),
    .decide(decide), .end_pass(end_pass), .rd_true(rd_true), .rd_cmpl(bus_rbit),
    .pos(pos), .prev_bit(cur_bit), .dir(dir), .more(more)
  );

  owsrch_idreg #(.ID_W(ID_W), .IDX_W(IDX_W)) u_idreg (
    .clk(clk), .rst_ns(rst_ns), .load_en(decide), .idx(idx), .dir(dir),
    .cur_bit(cur_bit), .id_q(id_out)
  );

endmodule

// File: tb/sim_owsrch_master.sv
module sim_owsrch_master;

  localparam int W = 6;
  localparam int NV = 1 << W;

  logic clk, rst_n, start, bus_req, bus_ack, bus_rbit, id_valid, busy, done, no_dev, err;
  logic [1:0]   bus_op;
  logic [W-1:0] id_out;

  owsrch_master #(.ID_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_op(bus_op),
    .bus_ack(bus_ack), .bus_rbit(bus_rbit), .id_out(id_out), .id_valid(id_valid),
    .busy(busy), .done(done), .no_dev(no_dev), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // population shared by processes (written only by the main flow)
  logic         mem [NV];
  logic [W-1:0] exp_id [NV];
  int           pop_n;
  logic         vanish;
  int           base_pass, base_emit;

  // per-process counters
  int chk_m, err_m, chk_e, err_e, chk_t, err_t;

  // slave population model and bit engine
  logic act [NV];
  int   phase, cc, sub, bi, passk, k;
  logic r, w;
  initial begin chk_m = 0; err_m = 0; passk = 0; phase = 0; end
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_rbit <= 1'b0; phase = 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      r = 1'b1;
      case (bus_op)
        2'd0: begin
          for (int v = 0; v < NV; v++) act[v] = mem[v] && !vanish;
          r = (pop_n > 0); phase = 1; cc = 0; sub = 0; bi = 0;
        end
        2'd1, 2'd2: begin
          w = (bus_op == 2'd2);
          chk_m++;
          if (phase == 1) begin
            if (w != ((8'hF0 >> cc) & 1)) begin
              err_m++; $display("FAIL R3 command bit %0d got %0b exp %0b", cc, w, (8'hF0 >> cc) & 1);
            end
            cc++; if (cc == 8) phase = 2;
          end else if (phase == 2 && sub == 2) begin
            k = passk - base_pass;
            if (k < 0 || k >= NV || w != exp_id[k][bi]) begin
              err_m++; $display("FAIL R5 pass %0d bit %0d wrote %0b exp %0b", k, bi, w,
                                (k >= 0 && k < NV) ? exp_id[k][bi] : 1'bx);
            end
            for (int v = 0; v < NV; v++) if (((v >> bi) & 1) != int'(w)) act[v] = 1'b0;
            bi++; sub = 0;
            if (bi == W) begin passk++; phase = 0; end
          end else begin
            err_m++; $display("FAIL R4 write out of order got phase %0d exp 2/sub 2", phase);
          end
        end
        default: begin
          chk_m++;
          if (phase == 2 && sub < 2) begin
            for (int v = 0; v < NV; v++)
              if (act[v]) r = r & ((sub == 0) ? ((v >> bi) & 1) : (((v >> bi) & 1) ^ 1));
            sub++;
          end else begin
            err_m++; $display("FAIL R4 read out of order got phase %0d sub %0d exp phase 2", phase, sub);
          end
        end
      endcase
      bus_ack <= 1'b1; bus_rbit <= r;
    end
  end

  // identity monitor
  int emitk;
  initial begin chk_e = 0; err_e = 0; emitk = 0; end
  always @(negedge clk) begin
    if (rst_n && id_valid) begin
      chk_e++;
      k = emitk - base_emit;
      if (k >= pop_n || k < 0 || id_out != exp_id[k]) begin
        err_e++; $display("FAIL R7/R8 emit %0d got %0h exp %0h", k, id_out,
                          (k >= 0 && k < NV) ? exp_id[k] : '0);
      end
      emitk++;
    end
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    chk_t++;
    if (act_v != exp_v) begin
      err_t++; $display("FAIL %s got %0d exp %0d", req, act_v, exp_v);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] x);
    for (int i = 0; i < W; i++) rev[i] = x[W-1-i];
  endfunction

  task automatic run(input int n, input int mul, input int add, input logic van, input logic poke);
    int c, lim;
    logic [W-1:0] v;
    c = 0;
    for (int x = 0; x < NV; x++) mem[(x * mul + add) % NV] = (x < n);
    for (int key = 0; key < NV; key++) begin
      v = rev(W'(key));
      if (mem[v]) begin exp_id[c] = v; c++; end
    end
    pop_n = van ? 0 : n; vanish = van;
    if (van) for (int x = 0; x < NV; x++) if (mem[x]) pop_n = n;
    base_pass = passk; base_emit = emitk;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R9 start clears flags", {done, no_dev, err}, 0);
    check("R2 busy after start", busy, 1);
    if (poke) begin
      repeat (25) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    lim = 0;
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
    check("watchdog run", lim < 20000, 1);
    if (n == 0) begin
      check("R2 no_dev", no_dev, 1);
      check("R2 no id", emitk - base_emit, 0);
    end else if (van) begin
      check("R6 err", err, 1);
      check("R6 done low", done, 0);
      check("R6 no id", emitk - base_emit, 0);
    end else begin
      check("R9 done", done, 1);
      check("R8 count", emitk - base_emit, n);
      if (poke) check("R10 stray start ignored", emitk - base_emit, n);
    end
    repeat (3) @(negedge clk);
    check("R9 flags hold", {done, no_dev, err}, (n == 0) ? 2 : (van ? 1 : 4));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", chk_m + chk_e + chk_t + 1, err_m + err_e + err_t + 1);
    $finish;
  end

  initial begin
    chk_t = 0; err_t = 0; start = 1'b0; rst_n = 1'b0; vanish = 1'b0; pop_n = 0;
    base_pass = 0; base_emit = 0;
    for (int x = 0; x < NV; x++) mem[x] = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {busy, bus_req, id_valid, done, no_dev, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {busy, bus_req, id_valid, done, no_dev, err}, 0);
    run(0, 1, 0, 1'b0, 1'b0);
    run(3, 5, 9, 1'b1, 1'b0);
    run(1, 1, 42, 1'b0, 1'b0);
    run(2, 1, 62, 1'b0, 1'b0);
    for (int n = 1; n <= 8; n++) run(n, 5 + 2 * n, 3 * n, 1'b0, 1'b0);
    run(17, 13, 7, 1'b0, 1'b1);
    run(32, 45, 1, 1'b0, 1'b0);
    run(NV, 1, 0, 1'b0, 1'b0);
    run(0, 3, 0, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", chk_m + chk_e + chk_t, err_m + err_e + err_t);
    $finish;
  end

endmodule